// File: doc/BRIEF.md
# Two-Register Single-Word Clock-Crossing FIFO

This block carries one data word at a time from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`, where the two clocks have no fixed phase or frequency relation. Both sides use the same data width. Two storage registers hold the data, but only one word can be in flight at a time. This keeps the occupancy flags down to a comparison of one-bit pointers.

Each side keeps a one-bit pointer that flips on every accepted transfer and also selects the storage register to use. Each pointer reaches the other domain through a chain of synchronizer flops. On the write side, full means the write pointer differs from the synchronized read pointer. On the read side, empty means the read pointer equals the synchronized write pointer. A producer waits for full to drop before it offers the next word. A consumer waits for empty to drop, then pulses its read enable and takes the word from the registered output after that edge.

Top module: `cdc_word_fifo`

## Requirements
- R1: While reset is applied and right after it is released, `rd_empty` is 1, `wr_full` is 0 and `rd_data` is 0.
- R2: A write is accepted when `wr_en` is 1 and `wr_full` is 0 at a rising `wr_clk` edge. The word is stored, and `wr_full` reads 1 straight after that edge.
- R3: A write offered while `wr_full` is 1 is ignored. The stored word is not overwritten, and no extra word later appears at the read side.
- R4: After an accepted write, `rd_empty` drops to 0 no later than the third rising `rd_clk` edge that follows the write edge. With the default two synchronizer stages it drops at the second such edge.
- R5: A read is accepted when `rd_en` is 1 and `rd_empty` is 0 at a rising `rd_clk` edge. At that edge `rd_data` takes the stored word, and `rd_empty` reads 1 straight after it.
- R6: A read offered while `rd_empty` is 1 is ignored. `rd_data` holds its value and `rd_empty` stays 1.
- R7: After an accepted read, `wr_full` drops to 0 no later than the third rising `wr_clk` edge that follows the read edge.
- R8: Words come out in the order they were accepted, with none lost and none repeated, while the two pointers alternate between the two registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-side asynchronous reset, active low |
| wr_en | input | 1 | Offer `wr_data` for storage |
| wr_data | input | WIDTH | Word to store |
| wr_full | output | 1 | A word is held; further writes are ignored |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-side asynchronous reset, active low |
| rd_en | input | 1 | Take the held word |
| rd_data | output | WIDTH | Registered output word, updated on an accepted read |
| rd_empty | output | 1 | No word is available to read |

## Verification
The bench keeps `wr_en` high while the FIFO is full, using a different value. A design that let that write through would overwrite the held word or deliver a phantom extra word. It also keeps `rd_en` high while the FIFO is empty. A design that acted on that read would change `rd_data` or flip its pointer and lose track of occupancy. The flag delays are timed in edges of the opposite clock, which catches a missing or extra synchronizer stage, a flag stuck high, or inverted pointer comparisons. A long stream with irregular gaps on both sides checks that the two registers alternate correctly: if both sides did not select the same register, the wrong or a stale word would come out.

// File: rtl/cdc_word_fifo.sv
module cdc_word_fifo #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_full,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_empty
);

  logic [WIDTH-1:0]       slot [2];
  logic                   wptr, rptr;
  logic [SYNC_STAGES-1:0] rptr_in_wr, wptr_in_rd;

  wire wr_take = wr_en && !wr_full;
  wire rd_take = rd_en && !rd_empty;

  assign wr_full  = wptr != rptr_in_wr[SYNC_STAGES-1];
  assign rd_empty = rptr == wptr_in_rd[SYNC_STAGES-1];

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wptr       <= 1'b0;
      rptr_in_wr <= '0;
    end else begin
      rptr_in_wr <= {rptr_in_wr[SYNC_STAGES-2:0], rptr};
      if (wr_take) wptr <= ~wptr;
    end

  always_ff @(posedge wr_clk)
    if (wr_take) slot[wptr] <= wr_data;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rptr       <= 1'b0;
      wptr_in_rd <= '0;
      rd_data    <= '0;
    end else begin
      wptr_in_rd <= {wptr_in_rd[SYNC_STAGES-2:0], wptr};
      if (rd_take) begin
        rd_data <= slot[rptr];
        rptr    <= ~rptr;
      end
    end

endmodule

module cdc_word_fifo_chk #(
  parameter int WIDTH = 8
) (
  input logic             wr_clk,
  input logic             wr_rst_n,
  input logic             wr_en,
  input logic             wr_full,
  input logic             wptr,
  input logic             rd_clk,
  input logic             rd_rst_n,
  input logic             rd_en,
  input logic             rd_empty,
  input logic             rptr,
  input logic [WIDTH-1:0] rd_data
);

  // R2
  full_after_write_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && !wr_full) |=> wr_full);

  // R3
  no_write_when_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |=> $stable(wptr));

  // R5
  empty_after_read_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && !rd_empty) |=> rd_empty);

  // R6
  no_read_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |=> $stable(rptr));

  // R6
  data_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_en && !rd_empty) |=> $stable(rd_data));

endmodule

bind cdc_word_fifo cdc_word_fifo_chk #(.WIDTH(WIDTH)) chk_i (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_full(wr_full), .wptr(wptr),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_empty(rd_empty), .rptr(rptr),
  .rd_data(rd_data)
);

// File: tb/cdc_word_fifo_tb_top.sv
module cdc_word_fifo_tb_top;
  localparam int WIDTH     = 8;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int NSTREAM   = 40;

  logic             wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic             wr_en = 0, rd_en = 0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic             wr_full, rd_empty;

  int checks = 0, failures = 0;
  logic [WIDTH-1:0] expq [$];

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  cdc_word_fifo #(.WIDTH(WIDTH), .SYNC_STAGES(2)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [WIDTH-1:0] d);
    @(negedge wr_clk);
    while (wr_full) @(negedge wr_clk);
    wr_en = 1; wr_data = d; expq.push_back(d);
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic get_word(input string req);
    logic [WIDTH-1:0] e;
    @(negedge rd_clk);
    while (rd_empty) @(negedge rd_clk);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    if (expq.size() == 0) begin
      check(0, {req, " unexpected word"}, rd_data, 0);
    end else begin
      e = expq.pop_front();
      check(rd_data == e, req, rd_data, e);
    end
  endtask

  initial begin
    #(WR_PERIOD*100000);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(WR_PERIOD*3);
    check(rd_empty == 1, "R1 empty in reset", rd_empty, 1);
    check(wr_full == 0, "R1 full in reset", wr_full, 0);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (3) @(negedge rd_clk);
    check(rd_empty == 1 && wr_full == 0, "R1 flags after reset", {wr_full, rd_empty}, 1);
    check(rd_data == 0, "R1 rd_data after reset", rd_data, 0);

    // R2: directed write
    @(negedge wr_clk);
    wr_en = 1; wr_data = 8'h5A; expq.push_back(8'h5A);
    @(posedge wr_clk);
    @(negedge wr_clk);
    check(wr_full == 1, "R2 full after write", wr_full, 1);
    // R3: offer a different word while full
    wr_data = 8'hC3;
    // R4: empty drops within three rd edges
    repeat (3) @(posedge rd_clk);
    @(negedge rd_clk);
    check(rd_empty == 0, "R4 empty drops", rd_empty, 0);
    @(negedge wr_clk);
    check(wr_full == 1, "R3 full held while writes offered", wr_full, 1);
    wr_en = 0;

    // R5: read gives the original word, empty asserts right after
    @(negedge rd_clk);
    rd_en = 1;
    @(posedge rd_clk);
    @(negedge rd_clk);
    rd_en = 0;
    check(rd_data == 8'h5A, "R3/R5 word not overwritten", rd_data, 8'h5A);
    check(rd_empty == 1, "R5 empty after read", rd_empty, 1);
    void'(expq.pop_front());

    // R7: full drops within three wr edges
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk);
    check(wr_full == 0, "R7 full drops", wr_full, 0);

    // R3: no phantom word from the ignored write
    repeat (8) @(negedge rd_clk);
    check(rd_empty == 1, "R3 no extra word", rd_empty, 1);

    // R6: read while empty ignored
    rd_en = 1;
    repeat (4) @(negedge rd_clk);
    rd_en = 0;
    check(rd_data == 8'h5A, "R6 rd_data held", rd_data, 8'h5A);
    check(rd_empty == 1, "R6 empty stays", rd_empty, 1);

    // R8: stream with irregular gaps on both sides
    fork
      for (int i = 0; i < NSTREAM; i++) begin
        put_word(WIDTH'((i * 37 + 11) ^ (i << 3)));
        if (i % 4 == 1) repeat (3) @(negedge wr_clk);
      end
      for (int j = 0; j < NSTREAM; j++) begin
        get_word("R8 stream order");
        if (j % 3 == 0) repeat (2) @(negedge rd_clk);
      end
    join
    check(expq.size() == 0, "R8 all words delivered", expq.size(), 0);
    repeat (6) @(negedge rd_clk);
    check(rd_empty == 1, "R8 empty after stream", rd_empty, 1);
    check(wr_full == 0, "R7 not full after stream", wr_full, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule